// File: doc/BRIEF.md
# Inverter Fault Supervisor

This block decides whether the six gate drives of a three-phase bridge may switch. It watches a digitized overcurrent comparator and a pair of comparator flags for every supply: the control supply and each of the high-side floating supplies. One flag of each pair says the supply is above the upper threshold. The other says it is below the lower threshold. A confirmed overcurrent, or a control supply that is too low, shuts down every gate and pulls the active-low fault line. A low high-side supply only disables the upper gate of its own phase.

An overcurrent has to persist for a programmable number of clock cycles before it counts as a trip, so short spikes are ignored. A trip is latched for at least a programmable clear interval. When that interval ends, the latch opens only if the comparator is quiet. Each supply lockout is hysteretic. It releases only on the upper-threshold flag and engages only on the lower-threshold flag. Between the two thresholds it holds its state.

All pins are plain level signals with no handshake. The outputs come straight from flops, so an input change shows at the outputs one clock edge later at the earliest.

Top module: `inv_fault_supervisor`

## Requirements
- R1: An overcurrent flag counts as a trip only when it is sampled high on FILT_CYC consecutive clock edges. Any shorter run changes no output, and one low sample restarts the count.
- R2: On the FILT_CYC-th consecutive high edge, `all_disable` goes to 1, every `hs_disable` bit goes to 1, and `fault_n` goes to 0.
- R3: A trip stays latched for at least CLR_CYC cycles. If the flag is low at the CLR_CYC-th edge after the trip edge, the latch releases at that edge.
- R4: The control-supply lockout releases on an edge where `vdd_above_hi`=1. It engages on an edge where `vdd_below_lo`=1. With both flags at 0 it keeps its state.
- R5: Each high-side supply i has its own lockout on `hs_above_hi[i]` and `hs_below_lo[i]`, with the same release, engage and hold rules as R4.
- R6: A locked high-side supply i sets only `hs_disable[i]`. It leaves `all_disable` at 0, `fault_n` at 1 and the other phases' bits unchanged.
- R7: `fault_n` is 0 exactly when the control supply is locked or an overcurrent trip is latched. A high-side lockout alone does not pull it low.
- R8: If the flag is still high at the CLR_CYC-th edge, the trip stays latched. It releases on the first edge at which the flag is sampled low.
- R9: After reset every supply is locked out and no trip is latched. The outputs are `fault_n`=0, `all_disable`=1 and all `hs_disable` bits = 1 until the upper-threshold flags are seen.
- R10: While the control supply is locked, `all_disable`=1 and every `hs_disable` bit is 1, whatever the state of the high-side supplies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw | input | 1 | Digitized overcurrent comparator, 1 = over threshold |
| vdd_above_hi | input | 1 | Control supply above its upper threshold |
| vdd_below_lo | input | 1 | Control supply below its lower threshold |
| hs_above_hi | input | PHASES | Per-phase high-side supply above its upper threshold |
| hs_below_lo | input | PHASES | Per-phase high-side supply below its lower threshold |
| all_disable | output | 1 | 1 = every gate (high and low side) forced off |
| hs_disable | output | PHASES | 1 = high-side gate of that phase forced off |
| fault_n | output | 1 | Active-low fault indication |

## Verification
A supply flag changes the outputs one edge after it is sampled. A trip becomes visible right after the FILT_CYC-th consecutive high edge. A release becomes visible after the CLR_CYC-th edge that follows the trip edge, or after the first later edge with the flag low. The bench drives inputs on the falling edge and records the expected output for each rising edge it wants checked. The monitor compares at the next falling edge, so each check lands on the exact edge where a result is due. Runs of one cycle short of the filter length and of the clear interval are checked as well, to pin down the boundaries.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  parameter int unsigned DEF_FILT_CYC = 53;
  parameter int unsigned DEF_CLR_CYC  = 4000;
  parameter int unsigned DEF_PHASES   = 3;

  typedef enum logic {
    SUP_LOCKED = 1'b0,
    SUP_RUN    = 1'b1
  } sup_state_e;
endpackage

// File: rtl/ifs_uvlo_cell.sv
module ifs_uvlo_cell
  import ifs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic above_hi,
  input  logic below_lo,
  output logic locked
);
  sup_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SUP_LOCKED;
    end else begin
      case (st)
        SUP_LOCKED: if (above_hi) st <= SUP_RUN;
        SUP_RUN:    if (below_lo) st <= SUP_LOCKED;
        default:    st <= SUP_LOCKED;
      endcase
    end
  end

  assign locked = (st == SUP_LOCKED);

  AST_UV_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SUP_LOCKED && !above_hi) |=> (st == SUP_LOCKED)); // R4
  AST_UV_HOLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SUP_RUN && !below_lo) |=> (st == SUP_RUN)); // R5
endmodule

// File: rtl/ifs_oc_filter.sv
module ifs_oc_filter #(
  parameter int unsigned FILT_CYC = ifs_pkg::DEF_FILT_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_raw,
  output logic confirm
);
  localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!oc_raw)      cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  // high on the cycle whose closing edge is the FILT_CYC-th high sample
  assign confirm = oc_raw && (cnt == LAST);

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_raw |=> (cnt == '0)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R1
endmodule

// File: rtl/ifs_trip_latch.sv
module ifs_trip_latch #(
  parameter int unsigned CLR_CYC = ifs_pkg::DEF_CLR_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic confirm,
  input  logic oc_raw,
  output logic tripped
);
  localparam int unsigned TW = (CLR_CYC < 2) ? 1 : $clog2(CLR_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(CLR_CYC - 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripped <= 1'b0;
      tmr     <= '0;
    end else if (!tripped) begin
      if (confirm) begin
        tripped <= 1'b1;
        tmr     <= '0;
      end
    end else if (tmr != LAST) begin
      tmr <= tmr + 1'b1;
    end else if (!oc_raw) begin
      tripped <= 1'b0;
    end
  end

  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && tmr != LAST) |=> tripped); // R3
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tripped) |-> !$past(oc_raw)); // R8
endmodule

// File: rtl/inv_fault_supervisor.sv
module inv_fault_supervisor #(
  parameter int unsigned FILT_CYC = ifs_pkg::DEF_FILT_CYC,
  parameter int unsigned CLR_CYC  = ifs_pkg::DEF_CLR_CYC,
  parameter int unsigned PHASES   = ifs_pkg::DEF_PHASES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_raw,
  input  logic              vdd_above_hi,
  input  logic              vdd_below_lo,
  input  logic [PHASES-1:0] hs_above_hi,
  input  logic [PHASES-1:0] hs_below_lo,
  output logic              all_disable,
  output logic [PHASES-1:0] hs_disable,
  output logic              fault_n
);
  localparam int unsigned NSUP = PHASES + 1;

  logic [NSUP-1:0] sup_hi, sup_lo, sup_locked;
  logic            oc_confirm, trip_q, vdd_locked;

  // index 0 is the control supply, 1..PHASES the high-side supplies
  assign sup_hi = {hs_above_hi, vdd_above_hi};
  assign sup_lo = {hs_below_lo, vdd_below_lo};

  for (genvar g = 0; g < NSUP; g++) begin : g_uvlo
    ifs_uvlo_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .above_hi (sup_hi[g]),
      .below_lo (sup_lo[g]),
      .locked   (sup_locked[g])
    );
  end

  ifs_oc_filter #(.FILT_CYC(FILT_CYC)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .oc_raw  (oc_raw),
    .confirm (oc_confirm)
  );

  ifs_trip_latch #(.CLR_CYC(CLR_CYC)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .confirm (oc_confirm),
    .oc_raw  (oc_raw),
    .tripped (trip_q)
  );

  assign vdd_locked  = sup_locked[0];
  assign all_disable = trip_q | vdd_locked;
  assign fault_n     = ~(trip_q | vdd_locked);
  assign hs_disable  = {PHASES{all_disable}} | sup_locked[NSUP-1:1];

  AST_TRIP_SHUTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> ((&hs_disable) && !fault_n)); // R2
  AST_HS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_q && !vdd_locked) |-> (fault_n && !all_disable)); // R6
  AST_VDD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vdd_locked) |-> ((&hs_disable) && !fault_n)); // R10
endmodule

// File: tb/inv_fault_supervisor_tb.sv
module inv_fault_supervisor_tb;
  localparam int FILT = 53;
  localparam int CLR  = 4000;
  localparam logic [4:0] RUN  = 5'b1_0_000;
  localparam logic [4:0] SHUT = 5'b0_1_111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic oc_raw = 1'b0, vdd_above_hi = 1'b0, vdd_below_lo = 1'b0;
  logic [2:0] hs_above_hi = '0, hs_below_lo = '0;
  logic all_disable, fault_n;
  logic [2:0] hs_disable;

  typedef struct { logic [4:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  inv_fault_supervisor #(.FILT_CYC(FILT), .CLR_CYC(CLR), .PHASES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw),
    .vdd_above_hi(vdd_above_hi), .vdd_below_lo(vdd_below_lo),
    .hs_above_hi(hs_above_hi), .hs_below_lo(hs_below_lo),
    .all_disable(all_disable), .hs_disable(hs_disable), .fault_n(fault_n)
  );

  // monitor: one expected item per checked rising edge, compared at the next falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [4:0] obs;
      it  = q.pop_front();
      obs = {fault_n, all_disable, hs_disable};
      checks++;
      if (obs !== it.exp) begin
        fails++;
        $display("FAIL %s: got %b expected %b", it.tag, obs, it.exp);
      end
    end
  end

  task automatic step(input bit chk, input logic [4:0] e, input string tag);
    @(posedge clk);
    if (chk) q.push_back('{exp: e, tag: tag});
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1, SHUT, "R9 in reset");
    step(1, SHUT, "R9 in reset");
    rst_n = 1'b1;
    step(1, SHUT, "R9 no rise flag seen");
    // high-side supplies come up first: control lockout still holds all off
    hs_above_hi = 3'b111;
    step(1, SHUT, "R10 control locked");
    vdd_above_hi = 1'b1;
    step(1, RUN, "R4 release");
    vdd_above_hi = 1'b0; hs_above_hi = 3'b000;
    step(1, RUN, "R4 hold between thresholds");
    step(1, RUN, "R5 hold between thresholds");
    // phase 1 high-side undervoltage
    hs_below_lo = 3'b010;
    step(1, 5'b1_0_010, "R6 phase-local lockout");
    hs_below_lo = 3'b000;
    step(1, 5'b1_0_010, "R5 hold locked");
    hs_above_hi = 3'b010;
    step(1, RUN, "R5 release");
    hs_above_hi = 3'b000;
    // glitch one cycle short of the filter
    oc_raw = 1'b1;
    for (int i = 0; i < FILT - 1; i++) step(1, RUN, "R1 short pulse");
    oc_raw = 1'b0;
    step(1, RUN, "R1 short pulse ignored");
    // confirmed trip
    oc_raw = 1'b1;
    for (int i = 0; i < FILT - 1; i++) step(1, RUN, "R1 before filter end");
    step(1, SHUT, "R2 trip at filter end");
    oc_raw = 1'b0;
    idle(CLR - 2);
    step(1, SHUT, "R3 one cycle before clear");
    step(1, RUN, "R3 release after clear");
    // trip with flag still high at end of clear interval
    oc_raw = 1'b1;
    for (int i = 0; i < FILT - 1; i++) step(1, RUN, "R1 refilter");
    step(1, SHUT, "R7 fault on trip");
    idle(CLR - 2);
    step(1, SHUT, "R3 hold");
    step(1, SHUT, "R8 flag high at clear end");
    step(1, SHUT, "R8 flag still high");
    oc_raw = 1'b0;
    step(1, RUN, "R8 release on quiet flag");
    // control-supply undervoltage
    vdd_below_lo = 1'b1;
    step(1, SHUT, "R10 control undervoltage");
    vdd_below_lo = 1'b0;
    step(1, SHUT, "R7 fault while control locked");
    vdd_above_hi = 1'b1;
    step(1, RUN, "R4 re-release");
    vdd_above_hi = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule